// File: doc/BRIEF.md
# Half-precision fused multiply-add

This block computes `a * b + c` on three 16-bit binary floating-point words and returns one 16-bit word. The full 22-bit significand product is kept unrounded. The addend is aligned to it, and the two are added exactly. The exact sum is then normalised and rounded a single time, to nearest with ties to even. Subnormal operands and results, signed zeros, infinities and NaNs are all handled.

Each word carries the sign in bit 15, a biased exponent in bits 14:10 (bias 15) and the fraction in bits 9:0. The unit is fully pipelined and accepts a new operation on every clock. An operation presented with `in_valid` high comes out four clock edges later with `out_valid` high. Four register stages lie on the path: input capture, multiply, align/add with leading-one location, and normalise/round into the output register. There is no back-pressure.

Top module: `fma16`

## Requirements
- R1: For finite operands the result is the exact value a*b+c rounded once to the nearest representable value, with ties going to the even fraction.
- R2: The product is not rounded before the addition. (1+2^-10)^2 - (1+2^-9), which is 0x3C01*0x3C01+0xBC02, gives 2^-20 = 0x0010.
- R3: `out_valid` equals the `in_valid` value sampled four rising edges earlier. `result` changes together with it, and one operation can be issued per cycle.
- R4: Exponent code 0 denotes a subnormal with an implicit leading 0 and weight 2^-14. Such inputs are exact, results below 2^-14 come out as correctly rounded subnormals, and a rounding carry moves into the smallest normal.
- R5: A finite result whose rounded magnitude exceeds 65504 (0x7BFF) becomes an infinity with the sign of the exact sum, encoded as exponent code 31 with fraction 0.
- R6: Any operand with exponent code 31 and a nonzero fraction (NaN) makes the result the canonical NaN 0x7E00. No other NaN encoding is ever produced.
- R7: Infinity times zero gives 0x7E00. An infinite product plus an opposite-signed infinite addend also gives 0x7E00. Otherwise an infinite product returns that infinity, and a finite product with an infinite addend returns the addend.
- R8: An exact zero sum of terms with opposite signs returns +0 (0x0000). A zero product plus a zero addend of the same sign keeps that sign.
- R9: While reset is low, and until the first operation emerges, `out_valid` is 0. During reset `result` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on this cycle form an operation |
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier |
| op_c | input | 16 | Addend |
| out_valid | output | 1 | `result` holds a finished operation |
| result | output | 16 | Rounded a*b+c |

## Verification
On every cycle, the assertions check the four-edge valid latency, the silence before the pipeline fills, NaN canonicalisation and propagation, the invalid infinity-times-zero case, and the sign of a zero product plus an opposite-signed zero. Correct rounding is shown only by the bench's scenarios, which compare each output against an exact scaled-integer model. These cover ties to even, single rounding of the product, subnormal underflow, the carry into the smallest normal, and overflow at the 65504/65520 boundary. The same scenarios also cover long random bursts.

// File: rtl/fma16.sv
module fma16 #(
  parameter int GUARD_LOW = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic [15:0] op_c,
  output logic        out_valid,
  output logic [15:0] result
);
  localparam int W    = GUARD_LOW + 65;
  localparam int PW   = $clog2(W);
  localparam int SOFF = 25 + GUARD_LOW;
  localparam int QOFF = 26 + GUARD_LOW;
  localparam int EOFF = 36 + GUARD_LOW;

  // input capture
  logic        v0;
  logic [15:0] a0, b0, c0;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v0 <= 1'b0; a0 <= '0; b0 <= '0; c0 <= '0;
    end else begin
      v0 <= in_valid; a0 <= op_a; b0 <= op_b; c0 <= op_c;
    end

  // multiply stage
  wire a_top = &a0[14:10], b_top = &b0[14:10], c_top = &c0[14:10];
  wire a_nan = a_top & |a0[9:0], b_nan = b_top & |b0[9:0], c_nan = c_top & |c0[9:0];
  wire a_inf = a_top & ~|a0[9:0], b_inf = b_top & ~|b0[9:0], c_inf = c_top & ~|c0[9:0];
  wire a_zero = ~|a0[14:0], b_zero = ~|b0[14:0];
  wire psign = a0[15] ^ b0[15];

  logic        sp;
  logic [15:0] sw;
  always_comb begin
    sp = 1'b1;
    sw = 16'h7E00;
    if (a_nan | b_nan | c_nan)
      sw = 16'h7E00;
    else if (a_inf | b_inf) begin
      if (a_zero | b_zero | (c_inf & (c0[15] != psign))) sw = 16'h7E00;
      else sw = {psign, 15'h7C00};
    end else if (c_inf)
      sw = c0;
    else
      sp = 1'b0;
  end

  wire [10:0] ma = {|a0[14:10], a0[9:0]};
  wire [10:0] mb = {|b0[14:10], b0[9:0]};
  wire [4:0]  ea = (|a0[14:10]) ? a0[14:10] : 5'd1;
  wire [4:0]  eb = (|b0[14:10]) ? b0[14:10] : 5'd1;
  wire [4:0]  ec = (|c0[14:10]) ? c0[14:10] : 5'd1;

  logic [21:0] row [0:11];
  assign row[0] = '0;
  generate
    for (genvar i = 0; i < 11; i++) begin : g_pp
      assign row[i+1] = row[i] + ((ma[i] ? {11'd0, mb} : 22'd0) << i);
    end
  endgenerate

  logic        v1, sp1, ps1, cs1;
  logic [15:0] sw1;
  logic [21:0] mp1;
  logic [5:0]  xp1;
  logic [10:0] mc1;
  logic [4:0]  ec1;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0; sp1 <= 1'b0; ps1 <= 1'b0; cs1 <= 1'b0; sw1 <= '0;
      mp1 <= '0; xp1 <= '0; mc1 <= '0; ec1 <= '0;
    end else begin
      v1 <= v0; sp1 <= sp; sw1 <= sw; ps1 <= psign; cs1 <= c0[15];
      mp1 <= row[11];
      xp1 <= {1'b0, ea} + {1'b0, eb};
      mc1 <= {|c0[14:10], c0[9:0]};
      ec1 <= ec;
    end

  // align / add stage
  wire [8:0]   shu = {4'd0, ec1} + 9'(SOFF) - {3'd0, xp1};
  wire [8:0]   nsh = 9'd0 - shu;
  wire [W-1:0] cw  = {{(W-11){1'b0}}, mc1};
  wire         lost = |(mc1 & ~(11'h7FF << nsh[4:0]));
  wire [W-1:0] aln = shu[8] ? ((cw >> nsh[4:0]) | {{(W-1){1'b0}}, lost})
                            : (cw << shu[6:0]);
  wire [W-1:0] pw  = {{(W-22){1'b0}}, mp1} << GUARD_LOW;
  wire         sub = ps1 ^ cs1;
  wire [W:0]   dif = {1'b0, pw} - {1'b0, aln};
  wire [W-1:0] mag = !sub ? W'(pw + aln) : dif[W] ? W'(0 - dif) : dif[W-1:0];
  wire         zro = ~|mag;
  wire         sgn = zro ? (ps1 & ~sub) : (sub & dif[W]) ? cs1 : ps1;

  logic [PW-1:0] lead;
  always_comb begin
    lead = '0;
    for (int i = 0; i < W; i++)
      if (mag[i]) lead = PW'(i);
  end

  logic          v2, sp2, z2, sg2;
  logic [15:0]   sw2;
  logic [W-1:0]  mag2;
  logic [5:0]    xp2;
  logic [PW-1:0] ld2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v2 <= 1'b0; sp2 <= 1'b0; z2 <= 1'b0; sg2 <= 1'b0; sw2 <= '0;
      mag2 <= '0; xp2 <= '0; ld2 <= '0;
    end else begin
      v2 <= v1; sp2 <= sp1; z2 <= zro; sg2 <= sgn; sw2 <= sw1;
      mag2 <= mag; xp2 <= xp1; ld2 <= lead;
    end

  // normalise / round stage
  wire signed [9:0] qv   = $signed(10'(QOFF)) - $signed({4'd0, xp2});
  wire signed [9:0] pm   = $signed(10'(ld2)) - 10'sd10;
  wire              norm = pm >= qv;
  wire [9:0]        rr   = norm ? pm : qv;
  wire [PW-1:0]     rsh  = rr[PW-1:0];
  wire [W+1:0]      ext  = {mag2, 2'b00};
  wire [10:0]       kept = 11'(ext >> (rsh + PW'(2)));
  wire              grd  = ext[rsh + PW'(1)];
  wire              stk  = |(ext & ~({(W+2){1'b1}} << (rsh + PW'(1))));
  wire              rup  = grd & (stk | kept[0]);
  wire [9:0]        base = norm ? ({4'd0, xp2} + 10'(ld2) - 10'(EOFF)) : 10'd0;
  wire [19:0]       big  = {base, 10'd0} + {9'd0, kept} + {19'd0, rup};
  wire [15:0]       fin  = sp2 ? sw2 :
                           z2  ? {sg2, 15'd0} :
                           (big >= 20'h7C00) ? {sg2, 15'h7C00} : {sg2, big[14:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; result <= '0;
    end else begin
      out_valid <= v2; result <= fin;
    end
endmodule

// File: rtl/fma16_props.sv
module fma16_props (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] op_a,
  input logic [15:0] op_b,
  input logic [15:0] op_c,
  input logic        out_valid,
  input logic [15:0] result
);
  logic [2:0] cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (cnt != 3'd7) cnt <= cnt + 3'd1;

  wire full = cnt >= 3'd4;
  wire nan_a = &op_a[14:10] & |op_a[9:0];
  wire nan_b = &op_b[14:10] & |op_b[9:0];
  wire nan_c = &op_c[14:10] & |op_c[9:0];
  wire any_nan = nan_a | nan_b | nan_c;
  wire inf_a = &op_a[14:10] & ~|op_a[9:0];
  wire inf_b = &op_b[14:10] & ~|op_b[9:0];
  wire zer_a = ~|op_a[14:0];
  wire zer_b = ~|op_b[14:0];
  wire zer_c = ~|op_c[14:0];
  wire inf_x_zero = (inf_a & zer_b) | (zer_a & inf_b);
  wire zero_cancel = ((zer_a & ~nan_b & ~inf_b) | (zer_b & ~nan_a & ~inf_a)) & zer_c &
                     ((op_a[15] ^ op_b[15]) != op_c[15]);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (out_valid == $past(in_valid, 4)));

  assert_idle_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !out_valid);

  assert_nan_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(in_valid && any_nan, 4)) |-> (result == 16'h7E00));

  assert_canonical_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&result[14:10]) && (|result[9:0])) |-> (result == 16'h7E00));

  assert_inf_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(in_valid && inf_x_zero, 4)) |-> (result == 16'h7E00));

  assert_zero_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(in_valid && zero_cancel, 4)) |-> (result == 16'h0000));
endmodule

bind fma16 fma16_props u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .op_a(op_a), .op_b(op_b), .op_c(op_c),
  .out_valid(out_valid), .result(result)
);

// File: tb/fma16_test.sv
module fma16_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0, op_c = '0;
  logic        out_valid;
  logic [15:0] result;

  int checks = 0;
  int fails = 0;

  logic        pv [0:3];
  logic [15:0] pw [0:3];
  string       pt [0:3];

  always #(CLK_PERIOD/2) clk = ~clk;

  fma16 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic [15:0] c);
    logic an, bn, cn, ai, bi, ci, az, bz, ps, sg;
    logic [127:0] pv_, cv_, sum, rem, half, kept;
    int ea, eb, ec, p, e, r;
    an = (a[14:10] == 5'd31) && (a[9:0] != 0);
    bn = (b[14:10] == 5'd31) && (b[9:0] != 0);
    cn = (c[14:10] == 5'd31) && (c[9:0] != 0);
    ai = (a[14:10] == 5'd31) && (a[9:0] == 0);
    bi = (b[14:10] == 5'd31) && (b[9:0] == 0);
    ci = (c[14:10] == 5'd31) && (c[9:0] == 0);
    az = a[14:0] == 0;
    bz = b[14:0] == 0;
    ps = a[15] ^ b[15];
    if (an || bn || cn) return 16'h7E00;
    if (ai || bi) begin
      if (az || bz) return 16'h7E00;
      if (ci && c[15] != ps) return 16'h7E00;
      return {ps, 15'h7C00};
    end
    if (ci) return c;
    ea = (a[14:10] == 0) ? 1 : int'(a[14:10]);
    eb = (b[14:10] == 0) ? 1 : int'(b[14:10]);
    ec = (c[14:10] == 0) ? 1 : int'(c[14:10]);
    // values scaled by 2^48
    pv_ = (128'({a[14:10] != 0, a[9:0]}) * 128'({b[14:10] != 0, b[9:0]})) << (ea + eb - 2);
    cv_ = 128'({c[14:10] != 0, c[9:0]}) << (ec + 23);
    if (ps == c[15]) begin sum = pv_ + cv_; sg = ps; end
    else if (pv_ >= cv_) begin sum = pv_ - cv_; sg = ps; end
    else begin sum = cv_ - pv_; sg = c[15]; end
    if (sum == 0) return {(ps == c[15]) ? ps : 1'b0, 15'd0};
    p = 0;
    for (int i = 0; i < 128; i++) if (sum[i]) p = i;
    e = p - 33;
    r = (e >= 1) ? p - 10 : 24;
    kept = sum >> r;
    rem = sum & ((128'd1 << r) - 1);
    half = 128'd1 << (r - 1);
    if (rem > half || (rem == half && kept[0])) kept = kept + 1;
    if (e >= 1) begin
      if (kept == 2048) begin kept = 1024; e = e + 1; end
      if (e >= 31) return {sg, 15'h7C00};
      return {sg, 5'(e), kept[9:0]};
    end
    return {sg, kept[14:0]};
  endfunction

  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                      input logic [15:0] c, input string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== pv[3] || (pv[3] && result !== pw[3])) begin
      fails++;
      $display("FAIL %s: valid=%0b result=%h, expected valid=%0b result=%h",
               pt[3], out_valid, result, pv[3], pw[3]);
    end
    for (int k = 3; k > 0; k--) begin
      pv[k] = pv[k-1]; pw[k] = pw[k-1]; pt[k] = pt[k-1];
    end
    in_valid = v; op_a = a; op_b = b; op_c = c;
    pv[0] = v;
    pw[0] = v ? model(a, b, c) : 16'h0000;
    pt[0] = v ? tag : "R3";
  endtask

  task automatic op(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                    input string tag);
    step(1'b1, a, b, c, tag);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin pv[k] = 1'b0; pw[k] = '0; pt[k] = "R9"; end
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== 16'h0000) begin
        fails++;
        $display("FAIL R9: in reset valid=%0b result=%h, expected valid=0 result=0000",
                 out_valid, result);
      end
    end
    rst_n = 1'b1;
    step(1'b0, 16'h0, 16'h0, 16'h0, "R9");
    step(1'b0, 16'h0, 16'h0, 16'h0, "R9");
    // R1 basic and ties
    op(16'h3C00, 16'h3C00, 16'h3C00, "R1");
    op(16'h3C00, 16'h3C00, 16'h1000, "R1");
    op(16'h3C00, 16'h3C00, 16'h1001, "R1");
    op(16'h3C01, 16'h3C00, 16'h1000, "R1");
    op(16'h4248, 16'hC500, 16'h5640, "R1");
    // R2 single rounding
    op(16'h3C01, 16'h3C01, 16'hBC02, "R2");
    op(16'h3BFF, 16'h3BFF, 16'hBBFE, "R2");
    // R4 subnormals
    op(16'h0001, 16'h3C00, 16'h0000, "R4");
    op(16'h0001, 16'h3800, 16'h0000, "R4");
    op(16'h0003, 16'h3800, 16'h0000, "R4");
    op(16'h03FF, 16'h3C00, 16'h0001, "R4");
    op(16'h0200, 16'h0200, 16'h8001, "R4");
    op(16'h0400, 16'h3800, 16'h0000, "R4");
    // R5 overflow
    op(16'h7BFF, 16'h3C00, 16'h7BFF, "R5");
    op(16'h7BFF, 16'hBC00, 16'h0000, "R5");
    op(16'h7BFF, 16'h3C00, 16'h4C00, "R5");
    op(16'h7BFF, 16'h3C00, 16'h4B00, "R5");
    op(16'h5C00, 16'hDC00, 16'h0000, "R5");
    // R6 NaN
    op(16'h7E01, 16'h3C00, 16'h0000, "R6");
    op(16'h3C00, 16'h7C01, 16'h7C00, "R6");
    op(16'h3C00, 16'h3C00, 16'hFC01, "R6");
    // R7 infinities
    op(16'h7C00, 16'h0000, 16'h3C00, "R7");
    op(16'h7C00, 16'h3C00, 16'hFC00, "R7");
    op(16'h7C00, 16'hBC00, 16'h3C00, "R7");
    op(16'h3C00, 16'h3C00, 16'h7C00, "R7");
    op(16'h8000, 16'hFC00, 16'h0000, "R7");
    // R8 zeros
    op(16'h3C00, 16'h3C00, 16'hBC00, "R8");
    op(16'h8000, 16'h3C00, 16'h8000, "R8");
    op(16'h0000, 16'hBC00, 16'h8000, "R8");
    op(16'h0000, 16'h3C00, 16'h8000, "R8");
    op(16'h0000, 16'h0000, 16'h0000, "R8");
    // R3 gaps and bursts
    step(1'b0, 16'h3C00, 16'h3C00, 16'h3C00, "R3");
    op(16'h4000, 16'h4000, 16'h0000, "R3");
    step(1'b0, 16'h0, 16'h0, 16'h0, "R3");
    step(1'b0, 16'h0, 16'h0, 16'h0, "R3");
    op(16'h4400, 16'h3800, 16'hC000, "R3");
    // R1 random streams
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] ra, rb, rc;
      ra = 16'($urandom());
      rb = 16'($urandom());
      rc = (n % 3 == 0) ? {~(ra[15] ^ rb[15]), 5'(ra[14:10] + rb[14:10] - 5'd15), rb[9:0]}
                        : 16'($urandom());
      step(($urandom() % 4) != 0, ra, rb, rc, "R1");
    end
    for (int n = 0; n < 6; n++) step(1'b0, 16'h0, 16'h0, 16'h0, "R3");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL R3: watchdog expired, actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule